// File: doc/BRIEF.md
# Software-Managed TLB Access Unit

A fully associative translation lookaside buffer whose entries are read, written and searched by software commands. Each entry holds a high word with the effective page number, page size and valid bit, a low word with the real page number and attributes, and an 8-bit process tag. The unit also holds an 8-bit process-ID (PID) register. Reading or writing an entry's high word moves that entry's tag out to the PID register or in from it. Low-word accesses leave both untouched.

A search adds two operands to form an effective address. It then returns the index of the lowest-numbered valid entry that translates the address, together with a found flag. If the index of the base register is zero, the base operand is taken as zero. A record form of the search also produces a 4-bit status field in place of condition-register bits. A synchronization command completes with no effect. Every command is accepted in one cycle and is answered by a one-cycle done pulse on the next cycle.

High-word layout: bits 31:10 hold the effective page number, bits 9:7 hold the size code s (page size 1 KB × 4^s, so s = 7 gives 16 MB), and bit 6 is the valid bit. Command codes: 0 none, 1 read, 2 write, 3 search, 4 search with status, 5 sync, 6 load PID from `wr_data[7:0]`.

Top module: `tlbu_top`

## Requirements
- R1: A read (cmd 1) with `ws`=0 returns the high word of entry `a_val[5:0]` on `rd_data` and loads the PID register with that entry's tag.
- R2: A write (cmd 2) with `ws`=0 stores `wr_data` as the high word of entry `a_val[5:0]` and stores the current PID into the entry's tag.
- R3: A read or write with `ws`=1 transfers only the low word; the PID register and the entry's tag keep their values.
- R4: A search forms the effective address as A + `b_val`, where A is `a_val`, or zero when `a_sel` is 0.
- R5: A search sets `found` when at least one entry matches and returns the lowest matching index on `hit_idx`; on a miss `found` is 0.
- R6: An entry matches only if its valid bit is set and address bits 31 down to 10+2s equal the same bits of its high word, where s is the entry's size code.
- R7: An entry matches only if its tag equals the PID register or is zero (a global entry).
- R8: A search with status (cmd 4) pulses `cr_we` and sets `cr` to {LT=0, GT=0, EQ=found, SO=`so_in`} (bits 3..0); the other commands leave `cr_we` at 0.
- R9: A sync (cmd 5) gives a done pulse and changes no entry and no PID value.
- R10: Every command with `cmd_valid` high gives `done`=1 on the next cycle; a cycle with no command gives `done`=0 on the next cycle.
- R11: Reset clears every valid bit and the PID register.
- R12: Cmd 6 loads the PID register from `wr_data[7:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd | input | 3 | Command code |
| ws | input | 1 | Word select: 0 high word, 1 low word |
| a_sel | input | 5 | Index of the base register; 0 means a zero base |
| a_val | input | 32 | A operand; bits 5:0 select the entry for read and write |
| b_val | input | 32 | B operand of the search |
| wr_data | input | 32 | Write data, or new PID value for cmd 6 |
| so_in | input | 1 | Summary-overflow bit passed into the status |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 32 | Read result |
| found | output | 1 | Search hit |
| hit_idx | output | 6 | Matching entry index (only meaningful when found) |
| cr_we | output | 1 | Status field updated |
| cr | output | 4 | Status {LT, GT, EQ, SO} |
| pid | output | 8 | PID register |

## Verification
On every cycle the assertions check the done pulse timing after each command and idle cycle, the consistency of the status field with the found flag, and that the PID register holds through low-word reads and sync. They also check the reset state. Only the bench's scenarios can show that a lookup uses address masking with the right page size, picks the lowest of several hits, matches global entries, and ignores the base operand when the base index is zero. The same holds for the tag and PID exchange on high-word accesses, which is compared against a behavioural model of the array.

// File: rtl/tlbu_pkg.sv
package tlbu_pkg;
  localparam int OFF_BITS = 10;   // smallest page: 1 KB
  localparam int SZ_LO    = 7;
  localparam int SZ_HI    = 9;
  localparam int V_BIT    = 6;

  typedef enum logic [2:0] {
    C_NOP    = 3'd0,
    C_READ   = 3'd1,
    C_WRITE  = 3'd2,
    C_SRCH   = 3'd3,
    C_SRCH_R = 3'd4,
    C_SYNC   = 3'd5,
    C_PIDSET = 3'd6
  } cmd_e;
endpackage

// File: rtl/tlbu_lo_ram.sv
module tlbu_lo_ram #(
  parameter int AW = 6,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wd,
  output logic [DW-1:0] q
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wd;
    if (re) q <= mem[addr];
  end
endmodule

// File: rtl/tlbu_cam.sv
module tlbu_cam import tlbu_pkg::*; #(
  parameter int IDXW = 6,
  parameter int DW   = 32,
  parameter int TAGW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [IDXW-1:0] idx,
  input  logic [DW-1:0]   wr_hi,
  input  logic [TAGW-1:0] wr_tag,
  input  logic [TAGW-1:0] cur_pid,
  input  logic [DW-1:0]   ea,
  output logic [DW-1:0]   rd_hi,
  output logic [TAGW-1:0] rd_tag,
  output logic            hit,
  output logic [IDXW-1:0] hit_idx
);
  localparam int N    = 1 << IDXW;
  localparam int EPNW = DW - OFF_BITS;

  logic [DW-1:0]   hi_mem  [N];
  logic [TAGW-1:0] tag_mem [N];
  logic [N-1:0]    vld;
  logic [N-1:0]    match;

  always_ff @(posedge clk) begin
    if (rst) vld <= '0;
    else if (wr_en) vld[idx] <= wr_hi[V_BIT];
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      hi_mem[idx]  <= wr_hi;
      tag_mem[idx] <= wr_tag;
    end
  end

  always_comb begin
    rd_hi        = hi_mem[idx];
    rd_hi[V_BIT] = vld[idx];
    rd_tag       = tag_mem[idx];
  end

  for (genvar g = 0; g < N; g++) begin : g_ent
    logic [EPNW-1:0] msk;
    logic            pg_ok, tag_ok;
    assign msk    = ~((EPNW'(1) << (2 * hi_mem[g][SZ_HI:SZ_LO])) - EPNW'(1));
    assign pg_ok  = ((ea[DW-1:OFF_BITS] ^ hi_mem[g][DW-1:OFF_BITS]) & msk) == '0;
    assign tag_ok = (tag_mem[g] == cur_pid) || (tag_mem[g] == '0);
    assign match[g] = vld[g] && pg_ok && tag_ok;
  end

  always_comb begin
    hit     = |match;
    hit_idx = '0;
    for (int i = N - 1; i >= 0; i--)
      if (match[i]) hit_idx = IDXW'(i);
  end
endmodule

// File: rtl/tlbu_top.sv
module tlbu_top import tlbu_pkg::*; #(
  parameter int IDXW = 6,
  parameter int DW   = 32,
  parameter int TAGW = 8,
  parameter int RSW  = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cmd_valid,
  input  logic [2:0]      cmd,
  input  logic            ws,
  input  logic [RSW-1:0]  a_sel,
  input  logic [DW-1:0]   a_val,
  input  logic [DW-1:0]   b_val,
  input  logic [DW-1:0]   wr_data,
  input  logic            so_in,
  output logic            done,
  output logic [DW-1:0]   rd_data,
  output logic            found,
  output logic [IDXW-1:0] hit_idx,
  output logic            cr_we,
  output logic [3:0]      cr,
  output logic [TAGW-1:0] pid
);
  logic [IDXW-1:0] idx;
  logic [DW-1:0]   ea, base, rd_hi, lo_q, hi_q;
  logic [TAGW-1:0] rd_tag, pid_q;
  logic            hit, rd_sel_q;
  logic [IDXW-1:0] cam_idx;
  logic            is_rd, is_wr, is_srch, is_rec;

  assign idx     = a_val[IDXW-1:0];
  assign base    = (a_sel == '0) ? '0 : a_val;
  assign ea      = base + b_val;
  assign is_rd   = cmd_valid && (cmd == C_READ);
  assign is_wr   = cmd_valid && (cmd == C_WRITE);
  assign is_rec  = cmd_valid && (cmd == C_SRCH_R);
  assign is_srch = (cmd_valid && (cmd == C_SRCH)) || is_rec;

  tlbu_cam #(.IDXW(IDXW), .DW(DW), .TAGW(TAGW)) u_cam (
    .clk(clk), .rst(rst), .wr_en(is_wr && !ws), .idx(idx),
    .wr_hi(wr_data), .wr_tag(pid_q), .cur_pid(pid_q), .ea(ea),
    .rd_hi(rd_hi), .rd_tag(rd_tag), .hit(hit), .hit_idx(cam_idx)
  );

  tlbu_lo_ram #(.AW(IDXW), .DW(DW)) u_lo (
    .clk(clk), .we(is_wr && ws), .re(is_rd && ws), .addr(idx),
    .wd(wr_data), .q(lo_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pid_q    <= '0;
      done     <= 1'b0;
      found    <= 1'b0;
      hit_idx  <= '0;
      cr_we    <= 1'b0;
      cr       <= '0;
      hi_q     <= '0;
      rd_sel_q <= 1'b0;
    end else begin
      done  <= cmd_valid;
      cr_we <= is_rec;
      found <= is_srch && hit;
      if (is_srch) hit_idx <= cam_idx;
      if (is_rec) cr <= {2'b00, hit, so_in};
      if (is_rd) begin
        rd_sel_q <= ws;
        if (!ws) begin
          hi_q  <= rd_hi;
          pid_q <= rd_tag;
        end
      end
      if (cmd_valid && cmd == C_PIDSET) pid_q <= wr_data[TAGW-1:0];
    end
  end

  assign rd_data = rd_sel_q ? lo_q : hi_q;
  assign pid     = pid_q;
endmodule

// File: rtl/tlbu_chk.sv
module tlbu_chk import tlbu_pkg::*; #(
  parameter int IDXW = 6,
  parameter int DW   = 32,
  parameter int TAGW = 8,
  parameter int RSW  = 5
) (
  input logic            clk,
  input logic            rst,
  input logic            cmd_valid,
  input logic [2:0]      cmd,
  input logic            ws,
  input logic            done,
  input logic            found,
  input logic            cr_we,
  input logic [3:0]      cr,
  input logic [TAGW-1:0] pid
);
  // R10
  done_after_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> done);
  // R10
  idle_no_done_chk: assert property (@(posedge clk) disable iff (rst)
    !cmd_valid |=> !done);
  // R8
  status_fields_chk: assert property (@(posedge clk) disable iff (rst)
    cr_we |-> (cr[3:2] == 2'b00) && (cr[1] == found));
  // R8
  status_only_rec_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd != C_SRCH_R) |=> !cr_we);
  // R3
  lo_read_pid_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd == C_READ && ws) |=> $stable(pid));
  // R9
  sync_inert_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd == C_SYNC) |=> $stable(pid) && !found);
  // R11
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (pid == '0) && !found && !done);
endmodule

bind tlbu_top tlbu_chk #(.IDXW(IDXW), .DW(DW), .TAGW(TAGW), .RSW(RSW)) u_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd(cmd), .ws(ws),
  .done(done), .found(found), .cr_we(cr_we), .cr(cr), .pid(pid)
);

// File: tb/tlbu_top_test.sv
module tlbu_top_test;
  localparam int PERIOD = 10;
  localparam int N = 64;

  logic        clk = 0, rst = 1;
  logic        cmd_valid = 0, ws = 0, so_in = 0;
  logic [2:0]  cmd = 0;
  logic [4:0]  a_sel = 0;
  logic [31:0] a_val = 0, b_val = 0, wr_data = 0;
  logic        done, found, cr_we;
  logic [31:0] rd_data;
  logic [5:0]  hit_idx;
  logic [3:0]  cr;
  logic [7:0]  pid;

  int checks = 0, bad = 0;
  bit finished = 0;

  logic [31:0] m_hi [N];
  logic [31:0] m_lo [N];
  logic [7:0]  m_tag [N];
  logic [7:0]  m_pid;

  tlbu_top uut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd(cmd), .ws(ws),
    .a_sel(a_sel), .a_val(a_val), .b_val(b_val), .wr_data(wr_data),
    .so_in(so_in), .done(done), .rd_data(rd_data), .found(found),
    .hit_idx(hit_idx), .cr_we(cr_we), .cr(cr), .pid(pid)
  );

  always #(PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  endtask

  // behavioural lookup: lowest valid entry whose page bits and tag agree
  task automatic lookup(input logic [31:0] ea, output bit hit, output int idx);
    hit = 0; idx = 0;
    for (int i = 0; i < N; i++) begin
      int sh;
      sh = 10 + 2 * int'(m_hi[i][9:7]);
      if (!hit && m_hi[i][6] && ((ea >> sh) == (m_hi[i] >> sh)) &&
          (m_tag[i] == m_pid || m_tag[i] == 8'h00)) begin
        hit = 1; idx = i;
      end
    end
  endtask

  task automatic issue(input logic [2:0] c, input logic w, input logic [4:0] as,
                       input logic [31:0] a, input logic [31:0] b,
                       input logic [31:0] d, input logic so, input string req);
    logic [31:0] exp_rd;
    bit exp_hit;
    int exp_idx;
    int e;
    @(negedge clk);
    cmd_valid = 1; cmd = c; ws = w; a_sel = as; a_val = a; b_val = b;
    wr_data = d; so_in = so;
    e = int'(a[5:0]);
    exp_rd = 0; exp_hit = 0; exp_idx = 0;
    if (c == 3'd3 || c == 3'd4) lookup(((as == 0) ? 32'h0 : a) + b, exp_hit, exp_idx);
    case (c)
      3'd1: if (w) exp_rd = m_lo[e];
            else begin exp_rd = m_hi[e]; m_pid = m_tag[e]; end
      3'd2: if (w) m_lo[e] = d;
            else begin m_hi[e] = d; m_tag[e] = m_pid; end
      3'd6: m_pid = d[7:0];
      default: ;
    endcase
    @(posedge clk);
    #1;
    check(done == 1'b1, {req, " (R10 done)"}, {31'h0, done}, 32'h1);
    check(pid == m_pid, {req, " pid"}, {24'h0, pid}, {24'h0, m_pid});
    check(cr_we == (c == 3'd4), {req, " (R8 cr_we)"}, {31'h0, cr_we}, {31'h0, c == 3'd4});
    if (c == 3'd1)
      check(rd_data == exp_rd, {req, " rd_data"}, rd_data, exp_rd);
    if (c == 3'd3 || c == 3'd4 || c == 3'd5)
      check(found == exp_hit, {req, " found"}, {31'h0, found}, {31'h0, exp_hit});
    if ((c == 3'd3 || c == 3'd4) && exp_hit)
      check(hit_idx == 6'(exp_idx), {req, " hit_idx"}, {26'h0, hit_idx}, exp_idx);
    if (c == 3'd4)
      check(cr == {2'b00, exp_hit, so}, {req, " (R8 cr)"}, {28'h0, cr}, {28'h0, 2'b00, exp_hit, so});
  endtask

  task automatic idle(input string req);
    @(negedge clk);
    cmd_valid = 0; cmd = 0;
    @(posedge clk);
    #1;
    check(done == 1'b0, req, {31'h0, done}, 32'h0);
  endtask

  initial begin
    #(PERIOD * 200000);
    check(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      m_hi[i] = 32'h0; m_lo[i] = 32'h0; m_tag[i] = 8'h0;
    end
    m_pid = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    #1;
    // R11: PID cleared, nothing valid
    check(pid == 8'h00, "R11 pid after reset", {24'h0, pid}, 32'h0);
    check(done == 1'b0, "R11 done after reset", {31'h0, done}, 32'h0);
    issue(3'd3, 0, 5'd1, 32'h0, 32'h0000_4000, 0, 0, "R11 search after reset");

    issue(3'd6, 0, 0, 0, 0, 32'h0000_0012, 0, "R12 pid load");
    issue(3'd2, 0, 0, 32'd5, 0, 32'h0000_4040, 0, "R2 write hi 5");
    issue(3'd2, 1, 0, 32'd5, 0, 32'hABCD_0123, 0, "R3 write lo 5");
    issue(3'd6, 0, 0, 0, 0, 32'h0000_0034, 0, "R12 pid load 34");
    issue(3'd1, 1, 0, 32'd5, 0, 0, 0, "R3 read lo 5 keeps pid");
    issue(3'd1, 0, 0, 32'd5, 0, 0, 0, "R1 read hi 5 loads pid");
    issue(3'd3, 0, 5'd3, 32'h0000_4000, 32'h0000_01FF, 0, 0, "R4 R5 search A+B");
    issue(3'd3, 0, 5'd0, 32'h9999_0000, 32'h0000_41FF, 0, 0, "R4 zero base");
    issue(3'd3, 0, 5'd3, 32'h9999_0000, 32'h0000_41FF, 0, 0, "R4 nonzero base misses");
    issue(3'd3, 0, 5'd0, 0, 32'h0000_4400, 0, 0, "R6 outside 1KB page");

    issue(3'd2, 0, 0, 32'd9, 0, 32'h0500_03C0, 0, "R2 write hi 9 16MB");
    issue(3'd3, 0, 5'd0, 0, 32'h05AB_CDEF, 0, 0, "R6 16MB page hit");
    issue(3'd3, 0, 5'd0, 0, 32'h0600_0000, 0, 0, "R6 16MB page miss");

    issue(3'd2, 0, 0, 32'd2, 0, 32'h0000_40C0, 0, "R2 write hi 2 4KB");
    issue(3'd3, 0, 5'd0, 0, 32'h0000_4100, 0, 0, "R5 lowest of two hits");
    issue(3'd3, 0, 5'd0, 0, 32'h0000_4C00, 0, 0, "R6 4KB page only");

    issue(3'd6, 0, 0, 0, 0, 32'h0000_0000, 0, "R12 pid zero");
    issue(3'd2, 0, 0, 32'd20, 0, 32'h0080_0040, 0, "R2 write global 20");
    issue(3'd6, 0, 0, 0, 0, 32'h0000_0055, 0, "R12 pid 55");
    issue(3'd3, 0, 5'd0, 0, 32'h0080_0010, 0, 0, "R7 global entry hit");
    issue(3'd3, 0, 5'd0, 0, 32'h0000_4000, 0, 0, "R7 tag mismatch miss");

    issue(3'd2, 0, 0, 32'd2, 0, 32'h0000_4080, 0, "R6 invalidate 2");
    issue(3'd6, 0, 0, 0, 0, 32'h0000_0012, 0, "R12 pid 12");
    issue(3'd3, 0, 5'd0, 0, 32'h0000_4100, 0, 0, "R6 invalid skipped");

    issue(3'd4, 0, 5'd0, 0, 32'h0000_4100, 0, 1, "R8 record hit so=1");
    issue(3'd4, 0, 5'd0, 0, 32'h0700_0000, 0, 0, "R8 record miss so=0");
    issue(3'd4, 0, 5'd0, 0, 32'h0700_0000, 0, 1, "R8 record miss so=1");

    issue(3'd5, 0, 0, 32'd9, 0, 32'hFFFF_FFFF, 0, "R9 sync");
    issue(3'd1, 0, 0, 32'd9, 0, 0, 0, "R9 entry 9 intact");
    idle("R10 no command no done");

    issue(3'd6, 0, 0, 0, 0, 32'h0000_0077, 0, "R12 pid 77");
    issue(3'd2, 1, 0, 32'd9, 0, 32'h1234_5678, 0, "R3 write lo 9");
    issue(3'd1, 1, 0, 32'd9, 0, 0, 0, "R3 read lo 9");
    issue(3'd1, 0, 0, 32'd9, 0, 0, 0, "R3 tag of 9 untouched by lo write");
    issue(3'd1, 0, 0, 32'd20, 0, 0, 0, "R1 read global hi 20");
    idle("R10 idle end");

    finish_run();
  end
endmodule